// File: doc/BRIEF.md
# Depth-Cue Colour Blend Unit

This block fades a stored base colour towards a far (fog) colour. It works on three channels and uses a signed 16-bit blend factor. A single start pulse latches the operands and the two mode bits. A sequencer then walks the three channels, one per cycle, through one shared multiplier.

For each channel the far colour is scaled up and the widened base is subtracted from it. The difference is clamped into a 16-bit intermediate value. That value is multiplied by the blend factor, and the widened base is added back. With the fraction-shift bit set, the sum is scaled down by 2^12.

The resulting accumulator is divided by 16 and clamped into an unsigned colour byte. The three bytes and a tag byte are pushed into a three-deep colour queue. The accumulator is also clamped into a 16-bit result register; the floor of that clamp depends on the limit bit.

The block serves as one operation of a fixed-point geometry and lighting engine. Its accumulator, intermediate and queue registers stay visible as outputs between operations.

Top module: `dq_depthcue`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every accumulator, result register, queue entry and flag output is zero, and busy_o and done_o are low.
- R2: A start_i sampled high while busy_o is low is accepted at that edge and busy_o goes high. The three channel steps take the next three edges. done_o is high for exactly the one cycle after the third step edge, and busy_o is low in that cycle.
- R3: The per-channel difference is D = (far << 12) - (base << 16), kept to 32 bits with wrap-around, so only the low 20 bits of the far colour matter. D is arithmetically shifted right by 12 when sf_i is set. It is clamped to -32768..32767 whatever lm_i is, and a clamp sets that channel's ir_sat_o.
- R4: mac_o of a channel equals (clamped D × ir0) + (base << 16), arithmetically shifted right by 12 when sf_i is set. Channel index 0 is red, 1 is green and 2 is blue.
- R5: The colour byte is mac_o divided by 16 with truncation towards zero, clamped to 0..255. col_sat_o for that channel is set only when the clamp acts, so an accumulator of -1..-15 gives byte 0 with no flag.
- R6: ir_o is mac_o clamped to 0..32767 when lm_i is set and to -32768..32767 otherwise. ir_sat_o is set if either the difference clamp or this clamp acts. All flags are cleared at an accepted start.
- R7: Each operation pushes one 32-bit word into the queue: bits 31:24 hold code_i, 23:16 blue, 15:8 green and 7:0 red. fifo_o[2] is the newest entry. A push moves entry 2 to 1 and entry 1 to 0, and the old entry 0 is lost.
- R8: start_i while busy_o is high is ignored. Operands and mode bits are used as latched at the accepted start, so changing them mid-operation has no effect on the results.
- R9: mac_pos_ovf_o and mac_neg_ovf_o flag a pre-shift sum outside the signed 44-bit range. For every operand combination of this operation the sum stays within it, so the flags stay clear.
- R10: While busy_o is low, mac_o, ir_o and fifo_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start an operation |
| sf_i | input | 1 | Fraction shift: scale results down by 2^12 |
| lm_i | input | 1 | Limit mode: floor the final result clamp at zero |
| base_i | input | 3x8 | Base colour bytes, index 0 red |
| code_i | input | 8 | Tag byte stored with the queued colour |
| far_i | input | 3x20 | Far colour, low 20 bits of each channel |
| ir0_i | input | 16 | Signed blend factor |
| mac_o | output | 3x32 | Accumulator per channel |
| ir_o | output | 3x16 | Clamped result per channel |
| fifo_o | output | 3x32 | Colour queue, entry 2 newest |
| ir_sat_o | output | 3 | Result clamp flags |
| col_sat_o | output | 3 | Colour byte clamp flags |
| mac_pos_ovf_o | output | 3 | Accumulator positive overflow flags |
| mac_neg_ovf_o | output | 3 | Accumulator negative overflow flags |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle. The first is a new start_i arriving while the sequencer is still stepping channels; the bench provokes it by pulsing start_i with changed operands in the middle of an operation. The second is the final channel's accumulator write coinciding with the queue push that consumes its colour byte. Both are judged against a behavioural per-channel model held in integers and a queue. The model is compared at completion and, for the held outputs, on every idle cycle.

// File: rtl/dq_pkg.sv
// Shared constants, result type and clamp helper for the depth-cue blend unit.
// Assumes a 32-bit accumulator, a 16-bit result register and a 12-bit fraction.
package dq_pkg;
    localparam int DQ_MAC_W  = 32;
    localparam int DQ_IR_W   = 16;
    localparam int DQ_FRAC   = 12;
    localparam int DQ_ACC_W  = 48;
    localparam int DQ_FAR_W  = DQ_MAC_W - DQ_FRAC;
    localparam int DQ_BYTE_W = 8;

    typedef struct packed {
        logic [DQ_IR_W-1:0] val;
        logic               sat;
    } dq_clamp_t;

    // Clamp a wide signed value into the result range; floor at zero if asked.
    function automatic dq_clamp_t dq_clamp(input logic signed [DQ_ACC_W-1:0] v,
                                           input logic floor_zero);
        dq_clamp_t r;
        logic signed [DQ_ACC_W-1:0] hi;
        logic signed [DQ_ACC_W-1:0] lo;
        hi = DQ_ACC_W'((64'sd1 <<< (DQ_IR_W-1)) - 64'sd1);
        lo = floor_zero ? '0 : ~hi;
        if (v > hi) begin
            r.val = hi[DQ_IR_W-1:0];
            r.sat = 1'b1;
        end else if (v < lo) begin
            r.val = lo[DQ_IR_W-1:0];
            r.sat = 1'b1;
        end else begin
            r.val = v[DQ_IR_W-1:0];
            r.sat = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/dq_lane.sv
// One channel of the blend, purely combinational: difference, clamp, multiply,
// add-back, optional fraction shift, byte and result clamps. Time-shared by
// the sequencer across the three channels, so it holds the only multiplier.
module dq_lane
    import dq_pkg::*;
#(
    parameter int GUARD_W = 44
) (
    input  logic [DQ_BYTE_W-1:0]        base_i,
    input  logic [DQ_FAR_W-1:0]         far_i,
    input  logic signed [DQ_IR_W-1:0]   ir0_i,
    input  logic                        sf_i,
    input  logic                        lm_i,
    output logic signed [DQ_MAC_W-1:0]  mac_o,
    output logic [DQ_IR_W-1:0]          ir_o,
    output logic [DQ_BYTE_W-1:0]        col_o,
    output logic                        ir_sat_o,
    output logic                        col_sat_o,
    output logic                        pos_ovf_o,
    output logic                        neg_ovf_o
);
    localparam logic signed [DQ_ACC_W-1:0] ACC_HI =
        DQ_ACC_W'((64'sd1 <<< (GUARD_W-1)) - 64'sd1);
    localparam logic signed [DQ_ACC_W-1:0] ACC_LO = ~ACC_HI;
    localparam int Q_W = DQ_MAC_W + 1;

    logic signed [DQ_MAC_W-1:0] base_w, diff_w, diff_s, prod_w, mac_w;
    logic signed [DQ_ACC_W-1:0] sum_w;
    logic signed [Q_W-1:0]      quot_w;
    dq_clamp_t                  step_c, fin_c;

    // Evaluate the whole channel datapath in one pass.
    always_comb begin
        base_w = $signed({8'd0, base_i, 16'd0});
        diff_w = $signed({far_i, {DQ_FRAC{1'b0}}}) - base_w;
        diff_s = sf_i ? (diff_w >>> DQ_FRAC) : diff_w;
        step_c = dq_clamp(DQ_ACC_W'(diff_s), 1'b0);
        prod_w = $signed(step_c.val) * ir0_i;
        sum_w  = DQ_ACC_W'(prod_w) + DQ_ACC_W'(base_w);
        pos_ovf_o = sum_w > ACC_HI;
        neg_ovf_o = sum_w < ACC_LO;
        mac_w  = sf_i ? sum_w[DQ_FRAC+DQ_MAC_W-1 -: DQ_MAC_W] : sum_w[DQ_MAC_W-1:0];
        quot_w = mac_w[DQ_MAC_W-1] ? ((Q_W'(mac_w) + Q_W'(15)) >>> 4)
                                   : (Q_W'(mac_w) >>> 4);
        if (quot_w < 0) begin
            col_o = '0;
            col_sat_o = 1'b1;
        end else if (quot_w > Q_W'(255)) begin
            col_o = '1;
            col_sat_o = 1'b1;
        end else begin
            col_o = quot_w[DQ_BYTE_W-1:0];
            col_sat_o = 1'b0;
        end
        fin_c    = dq_clamp(DQ_ACC_W'(mac_w), lm_i);
        ir_o     = fin_c.val;
        ir_sat_o = step_c.sat | fin_c.sat;
        mac_o    = mac_w;
    end
endmodule

// File: rtl/dq_seq.sv
// Channel sequencer: accepts a start when idle, then steps one channel per
// edge and flags the last step. Assumes CH >= 2.
module dq_seq #(
    parameter int CH = 3,
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    output logic           load_o,
    output logic           step_o,
    output logic           last_o,
    output logic           busy_o,
    output logic [CHW-1:0] ch_o
);
    logic           busy_q;
    logic [CHW-1:0] ch_q;

    // Decode the control strobes from the current state.
    always_comb begin
        load_o = start_i & ~busy_q;
        step_o = busy_q;
        last_o = busy_q && (ch_q == CHW'(CH-1));
        busy_o = busy_q;
        ch_o   = ch_q;
    end

    // Advance the channel counter and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ch_q   <= '0;
        end else if (load_o) begin
            busy_q <= 1'b1;
            ch_q   <= '0;
        end else if (last_o) begin
            busy_q <= 1'b0;
            ch_q   <= '0;
        end else if (step_o) begin
            ch_q   <= ch_q + 1'b1;
        end
    end
endmodule

// File: rtl/dq_cfifo.sv
// Shift-style colour queue: entry DEPTH-1 is newest, a push drops entry 0.
module dq_cfifo #(
    parameter int DEPTH = 3,
    parameter int W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [W-1:0]              din_i,
    output logic [DEPTH-1:0][W-1:0]   q_o
);
    // Load the newest slot on a push.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o[DEPTH-1] <= '0;
        else if (push_i) q_o[DEPTH-1] <= din_i;
    end

    for (genvar i = 0; i < DEPTH-1; i++) begin : g_shift
        // Move each older slot one place towards the oldest on a push.
        always_ff @(posedge clk) begin
            if (!rst_n)      q_o[i] <= '0;
            else if (push_i) q_o[i] <= q_o[i+1];
        end
    end
endmodule

// File: rtl/dq_depthcue.sv
// Depth-cue colour blend unit. Latches operands on an accepted start, runs the
// shared lane over the channels one per cycle, registers each channel's
// results, and pushes the packed colour word on the last step.
// Assumes CH >= 2 and FIFO_DEPTH >= 2.
module dq_depthcue
    import dq_pkg::*;
#(
    parameter int CH         = 3,
    parameter int FIFO_DEPTH = 3,
    parameter int GUARD_W    = 44,
    localparam int WORD_W    = DQ_BYTE_W * (CH + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic                                sf_i,
    input  logic                                lm_i,
    input  logic [CH-1:0][DQ_BYTE_W-1:0]        base_i,
    input  logic [DQ_BYTE_W-1:0]                code_i,
    input  logic [CH-1:0][DQ_FAR_W-1:0]         far_i,
    input  logic [DQ_IR_W-1:0]                  ir0_i,
    output logic [CH-1:0][DQ_MAC_W-1:0]         mac_o,
    output logic [CH-1:0][DQ_IR_W-1:0]          ir_o,
    output logic [FIFO_DEPTH-1:0][WORD_W-1:0]   fifo_o,
    output logic [CH-1:0]                       ir_sat_o,
    output logic [CH-1:0]                       col_sat_o,
    output logic [CH-1:0]                       mac_pos_ovf_o,
    output logic [CH-1:0]                       mac_neg_ovf_o,
    output logic                                busy_o,
    output logic                                done_o
);
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1;

    logic                             load, step, last;
    logic [CHW-1:0]                   ch;
    logic [CH-1:0][DQ_BYTE_W-1:0]     lat_base;
    logic [CH-1:0][DQ_FAR_W-1:0]      lat_far;
    logic [DQ_IR_W-1:0]               lat_ir0;
    logic [DQ_BYTE_W-1:0]             lat_code;
    logic                             lat_sf, lat_lm;
    logic [CH-2:0][DQ_BYTE_W-1:0]     col_hold;
    logic [WORD_W-1:0]                push_word;

    logic signed [DQ_MAC_W-1:0]       l_mac;
    logic [DQ_IR_W-1:0]               l_ir;
    logic [DQ_BYTE_W-1:0]             l_col;
    logic                             l_irs, l_cs, l_po, l_no;

    dq_seq #(.CH(CH)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .step_o(step), .last_o(last), .busy_o(busy_o), .ch_o(ch)
    );

    dq_lane #(.GUARD_W(GUARD_W)) lane_i (
        .base_i(lat_base[ch]), .far_i(lat_far[ch]), .ir0_i($signed(lat_ir0)),
        .sf_i(lat_sf), .lm_i(lat_lm),
        .mac_o(l_mac), .ir_o(l_ir), .col_o(l_col),
        .ir_sat_o(l_irs), .col_sat_o(l_cs), .pos_ovf_o(l_po), .neg_ovf_o(l_no)
    );

    // Capture operands and mode bits at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_base <= '0;
            lat_far  <= '0;
            lat_ir0  <= '0;
            lat_code <= '0;
            lat_sf   <= 1'b0;
            lat_lm   <= 1'b0;
        end else if (load) begin
            lat_base <= base_i;
            lat_far  <= far_i;
            lat_ir0  <= ir0_i;
            lat_code <= code_i;
            lat_sf   <= sf_i;
            lat_lm   <= lm_i;
        end
    end

    // Register per-channel results and flags; clear flags on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_o         <= '0;
            ir_o          <= '0;
            ir_sat_o      <= '0;
            col_sat_o     <= '0;
            mac_pos_ovf_o <= '0;
            mac_neg_ovf_o <= '0;
            col_hold      <= '0;
            done_o        <= 1'b0;
        end else begin
            done_o <= last;
            if (load) begin
                ir_sat_o      <= '0;
                col_sat_o     <= '0;
                mac_pos_ovf_o <= '0;
                mac_neg_ovf_o <= '0;
            end
            if (step) begin
                mac_o[ch]         <= l_mac;
                ir_o[ch]          <= l_ir;
                ir_sat_o[ch]      <= l_irs;
                col_sat_o[ch]     <= l_cs;
                mac_pos_ovf_o[ch] <= l_po;
                mac_neg_ovf_o[ch] <= l_no;
                if (!last) col_hold[ch] <= l_col;
            end
        end
    end

    // Pack the queued word: tag byte on top, channel 0 in the low byte.
    always_comb begin
        push_word = '0;
        push_word[WORD_W-1 -: DQ_BYTE_W] = lat_code;
        for (int i = 0; i < CH-1; i++) push_word[DQ_BYTE_W*i +: DQ_BYTE_W] = col_hold[i];
        push_word[DQ_BYTE_W*(CH-1) +: DQ_BYTE_W] = l_col;
    end

    dq_cfifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(last), .din_i(push_word), .q_o(fifo_o)
    );
endmodule

// File: rtl/dq_depthcue_chk.sv
// Protocol and hold checks for the depth-cue blend unit, bound to the top.
module dq_depthcue_chk #(
    parameter int CH = 3,
    parameter int FIFO_DEPTH = 3,
    parameter int WORD_W = 32
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               start_i,
    input logic                               busy_o,
    input logic                               done_o,
    input logic [CH-1:0][31:0]                mac_o,
    input logic [CH-1:0][15:0]                ir_o,
    input logic [FIFO_DEPTH-1:0][WORD_W-1:0]  fifo_o,
    input logic [CH-1:0]                      ir_sat_o,
    input logic [CH-1:0]                      col_sat_o,
    input logic [CH-1:0]                      mac_pos_ovf_o,
    input logic [CH-1:0]                      mac_neg_ovf_o
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (ir_sat_o == '0 && col_sat_o == '0));
    // R7
    fifo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fifo_o[0] == $past(fifo_o[1])));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_pos_ovf_o == '0 && mac_neg_ovf_o == '0));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(mac_o) && $stable(ir_o) && $stable(fifo_o)));
endmodule

bind dq_depthcue dq_depthcue_chk #(.CH(CH), .FIFO_DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .mac_o(mac_o), .ir_o(ir_o), .fifo_o(fifo_o), .ir_sat_o(ir_sat_o),
    .col_sat_o(col_sat_o), .mac_pos_ovf_o(mac_pos_ovf_o), .mac_neg_ovf_o(mac_neg_ovf_o)
);

// File: tb/dq_depthcue_tb_top.sv
// Bench for the depth-cue blend unit: behavioural integer model, queue-based
// colour queue model, checks at completion and on every idle cycle.
module dq_depthcue_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, sf_i = 1'b0, lm_i = 1'b0;
    logic [2:0][7:0]  base_i = '0;
    logic [7:0]       code_i = '0;
    logic [2:0][19:0] far_i = '0;
    logic [15:0]      ir0_i = '0;
    logic [2:0][31:0] mac_o;
    logic [2:0][15:0] ir_o;
    logic [2:0][31:0] fifo_o;
    logic [2:0]       ir_sat_o, col_sat_o, mac_pos_ovf_o, mac_neg_ovf_o;
    logic             busy_o, done_o;

    int nchk = 0, nerr = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    int exp_mac [3];
    int exp_ir [3];
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    dq_depthcue dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sf_i(sf_i), .lm_i(lm_i),
        .base_i(base_i), .code_i(code_i), .far_i(far_i), .ir0_i(ir0_i),
        .mac_o(mac_o), .ir_o(ir_o), .fifo_o(fifo_o), .ir_sat_o(ir_sat_o),
        .col_sat_o(col_sat_o), .mac_pos_ovf_o(mac_pos_ovf_o),
        .mac_neg_ovf_o(mac_neg_ovf_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int clampv(input longint v, input longint lo, input longint hi,
                                  output bit s);
        s = 1'b1;
        if (v > hi) return int'(hi);
        if (v < lo) return int'(lo);
        s = 1'b0;
        return int'(v);
    endfunction

    // Behavioural model of one channel, from the requirements.
    function automatic void model_ch(input int base, input int fc, input int ir0,
                                     input bit sf, input bit lm,
                                     output int mac, output int ir, output int col,
                                     output bit irs, output bit cs,
                                     output bit po, output bit no);
        longint d, s;
        int d32, ira;
        bit s1, s2;
        d = longint'(fc) * 4096 - longint'(base) * 65536;
        d32 = int'(d);
        if (sf) d32 = d32 >>> 12;
        ira = clampv(d32, -32768, 32767, s1);
        s = longint'(ira) * longint'(ir0) + longint'(base) * 65536;
        po = s > 64'sh7FF_FFFF_FFFF;
        no = s < -64'sh800_0000_0000;
        if (sf) s = s >>> 12;
        mac = int'(s);
        col = mac / 16;
        cs = 1'b0;
        if (col < 0) begin col = 0; cs = 1'b1; end
        else if (col > 255) begin col = 255; cs = 1'b1; end
        ir = clampv(mac, lm ? 0 : -32768, 32767, s2);
        irs = s1 | s2;
    endfunction

    // Per-cycle comparison of held outputs while idle (R10).
    always begin
        @(negedge clk);
        #5;
        if (mon_en && !busy_o) begin
            for (int c = 0; c < 3; c++)
                chk($signed(mac_o[c]) == exp_mac[c], "R10", "idle mac", $signed(mac_o[c]), exp_mac[c]);
            for (int k = 0; k < 3; k++)
                chk(fifo_o[k] == exp_q[k], "R10", "idle fifo", fifo_o[k], exp_q[k]);
        end
    end

    task automatic run_op(input int b0, input int b1, input int b2, input int code,
                          input int f0, input int f1, input int f2, input int ir0v,
                          input bit sfv, input bit lmv, input bit glitch, input string req);
        int bs [3];
        int fs [3];
        int m, irv, col;
        bit irs, cs, po, no;
        logic [31:0] word;
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        fs[0] = f0; fs[1] = f1; fs[2] = f2;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            base_i[c] = bs[c][7:0];
            far_i[c]  = fs[c][19:0];
        end
        code_i = code[7:0]; ir0_i = ir0v[15:0]; sf_i = sfv; lm_i = lmv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after accept", busy_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R2", "done early", done_o, 0);
        if (glitch) begin
            start_i = 1'b1;
            for (int c = 0; c < 3; c++) begin
                base_i[c] = ~base_i[c];
                far_i[c]  = far_i[c] ^ 20'h5A5A5;
            end
            ir0_i = ~ir0_i; sf_i = ~sf_i; lm_i = ~lm_i; code_i = ~code_i;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R2", "done early", done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b1, "R2", "done on third step", done_o, 1);
        chk(busy_o == 1'b0, "R2", "idle at done", busy_o, 0);
        word = {code[7:0], 24'd0};
        for (int c = 0; c < 3; c++) begin
            model_ch(bs[c], fs[c], int'($signed(ir0v[15:0])), sfv, lmv, m, irv, col, irs, cs, po, no);
            exp_mac[c] = m;
            exp_ir[c] = irv;
            word[8*c +: 8] = col[7:0];
            chk($signed(mac_o[c]) == m, req, "mac (R4)", $signed(mac_o[c]), m);
            chk($signed(ir_o[c]) == irv, req, "ir (R6)", $signed(ir_o[c]), irv);
            chk(ir_sat_o[c] == irs, req, "ir_sat (R3)", ir_sat_o[c], irs);
            chk(col_sat_o[c] == cs, req, "col_sat (R5)", col_sat_o[c], cs);
            chk(mac_pos_ovf_o[c] == po && mac_neg_ovf_o[c] == no, "R9", "ovf flags",
                {mac_pos_ovf_o[c], mac_neg_ovf_o[c]}, {po, no});
        end
        exp_q.push_back(word);
        void'(exp_q.pop_front());
        for (int k = 0; k < 3; k++)
            chk(fifo_o[k] == exp_q[k], "R7", "fifo entry", fifo_o[k], exp_q[k]);
        @(negedge clk);
        chk(done_o == 1'b0, "R2", "done single cycle", done_o, 0);
    endtask

    initial begin
        logic [31:0] lf;
        for (int k = 0; k < 3; k++) exp_q.push_back(32'd0);
        for (int c = 0; c < 3; c++) begin exp_mac[c] = 0; exp_ir[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(mac_o == '0 && ir_o == '0, "R1", "mac/ir reset", {mac_o[0], ir_o[0]}, 0);
        chk(fifo_o == '0, "R1", "fifo reset", fifo_o[2], 0);
        chk({ir_sat_o, col_sat_o, mac_pos_ovf_o, mac_neg_ovf_o} == '0, "R1", "flags reset",
            {ir_sat_o, col_sat_o, mac_pos_ovf_o, mac_neg_ovf_o}, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done reset", {busy_o, done_o}, 0);
        mon_en = 1'b1;
        // R4 R5: fractional blend, mid-range values
        run_op(8'h80, 8'h40, 8'h10, 8'h2C, 32'h200, 32'h100, 32'h800, 32'h800, 1, 0, 0, "R4");
        // R3: integer mode, difference clamps
        run_op(8'h80, 8'h00, 8'hFF, 8'h11, 0, 3, -2, 32'h1000, 0, 0, 0, "R3");
        // R6: limit mode floors negative result at zero
        run_op(8'hFF, 8'h20, 8'h01, 8'h77, -32'h1000, -32'h40, -5, 32'h1000, 1, 1, 0, "R6");
        // R5: colour above 255 clamps
        run_op(8'h10, 8'h00, 8'hF0, 8'h99, 32'h2000, 32'h7FFF, 32'h0F00, 32'h1000, 1, 0, 0, "R5");
        // R5: accumulator of -1 truncates to byte 0 without a flag
        run_op(0, 0, 0, 8'h05, -1, -16, -17, 20, 1, 0, 0, "R5");
        // R3: upper far-colour bits wrap away
        run_op(8'h33, 8'h44, 8'h55, 8'hA0, 32'hABC12345, 32'h7FF00010, 32'hFFF80000, 32'h0123, 0, 0, 0, "R3");
        // R9: extreme operands
        run_op(8'hFF, 8'h00, 8'hFF, 8'hFF, 32'h7FFFF, 32'h80000, 32'h80000, -32768, 0, 0, 0, "R9");
        run_op(8'h00, 8'hFF, 8'h00, 8'h00, 32'h80000, 32'h7FFFF, 32'h7FFFF, -32768, 0, 1, 0, "R9");
        // R8: start pulsed mid-operation with altered operands
        run_op(8'h12, 8'h34, 8'h56, 8'h3C, 32'h300, -32'h100, 32'h40, 32'h0C00, 1, 1, 1, "R8");
        // R7: further pushes with varied data
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 8; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_op(lf[7:0], lf[15:8], lf[23:16], int'(lf[31:24]),
                   int'({{12{lf[19]}}, lf[19:0]}), int'(lf[27:8]) - 32'h40000,
                   int'(lf[11:0]), int'($signed(lf[25:10])), lf[3], lf[5], n[0], "R7");
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule